// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register store of a two-port, sixteen-pin I/O expander. A byte-wide access interface reaches it, typically the back end of a serial slave. A load strobe sets an internal address pointer. Each following write strobe stores one byte at the pointer. Each read strobe accepts the byte shown on the read data output. Both ports own eleven byte registers: direction, input polarity, interrupt enable, compare value, interrupt control, the shared configuration slot, pull-up enable, interrupt flag, interrupt capture, port and output latch. That order sets their relative offsets.

One configuration register serves both ports. Bit 7 selects the address layout. When it is 0, the map is interleaved: register index i of port A sits at address 2i and port B sits at 2i+1. When it is 1, the map is separated: port A sits at address i and port B at 0x10+i. Bit 5 holds the pointer in place after each data byte. When bit 5 is clear, the pointer advances and wraps to 0x00 after the last mapped address. The direction and latch registers drive the pad enables and pad values directly. The flag and capture registers reflect inputs from the interrupt logic, which lives outside this block.

Top module: `gpx_regfile`

## Requirements
- R1: After reset all direction bits are 1, so every pad enable is 0. Every other register is 0, the interleaved map is active and the pointer is 0x00.
- R2: With configuration bit 7 at 0, register index i (0..10) of port A is at address 2i and that of port B at 2i+1. Addresses 0x16 and above are unmapped.
- R3: With configuration bit 7 at 1, index i of port A is at address i and that of port B at 0x10+i. The new map applies from the cycle after the configuration write.
- R4: Index 5 of either port is the same configuration register. A write through one address is read back through the other.
- R5: With configuration bit 5 at 1, the pointer stays unchanged after each read or write strobe.
- R6: With configuration bit 5 at 0, each strobe advances the pointer by one. After the last mapped address (0x15 interleaved, 0x1A separated) the pointer returns to 0x00.
- R7: Pad enable bit n is the inverse of direction bit n. Pad output bit n is output latch bit n. Port A maps to bits 7:0.
- R8: A read of the port register returns the pad input XOR the polarity register, whatever the direction. A read of the output latch returns the latch.
- R9: A write to the port register (index 9) updates the output latch of that port.
- R10: Unmapped addresses read 0x00 and ignore writes. The flag (index 7) and capture (index 8) registers read the interrupt inputs and ignore writes.
- R11: A load strobe takes priority over a write or read strobe in the same cycle. The pointer is loaded and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_ld | input | 1 | Load pointer from acc_addr |
| acc_addr | input | 8 | Register address |
| acc_wr | input | 1 | Write acc_wdata at pointer |
| acc_rd | input | 1 | Read byte accepted, step pointer |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Data at current pointer |
| pad_in | input | 16 | Sampled pad levels |
| pad_oe | output | 16 | Pad driver enables |
| pad_out | output | 16 | Pad drive values |
| pull_en | output | 16 | Pull-up enables |
| int_flag | input | 16 | Interrupt flags from interrupt logic |
| int_cap | input | 16 | Captured port state from interrupt logic |
| cfg | output | 8 | Shared configuration register |

## Verification
A wrong pointer shows on acc_rdata at the very next read, because the output always presents the byte at the pointer. A stuck hold bit or a missed wrap therefore returns a neighbouring register's value at once. A decode error in either map shows as a swapped or zero byte the first time that address is read. A write into a read-only or unmapped slot is caught when the nearby registers are read back. A corrupted direction or latch byte appears on pad_oe or pad_out one cycle after the write.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_PORTS   = 2;
    localparam int REG_CNT     = 11;
    localparam int SEP_STRIDE  = 16;
    localparam int CFG_MAP_BIT = 7;
    localparam int CFG_HLD_BIT = 5;
    localparam int PIN_W       = DATA_W * NUM_PORTS;

    typedef enum logic [3:0] {
        IDX_DIR  = 4'd0,
        IDX_POL  = 4'd1,
        IDX_IEN  = 4'd2,
        IDX_DFLT = 4'd3,
        IDX_ICTL = 4'd4,
        IDX_CFG  = 4'd5,
        IDX_PULL = 4'd6,
        IDX_FLAG = 4'd7,
        IDX_CAP  = 4'd8,
        IDX_PORT = 4'd9,
        IDX_LAT  = 4'd10
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] pol;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] dflt;
        logic [DATA_W-1:0] ictl;
        logic [DATA_W-1:0] pull;
        logic [DATA_W-1:0] lat;
    } port_regs_t;
endpackage

// File: rtl/gpx_map.sv
module gpx_map
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sep_mode,
    output logic              hit,
    output logic              port_b,
    output reg_idx_e          idx,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int ILV_SPAN = 2 * REG_CNT;
    localparam int SEP_LAST = SEP_STRIDE + REG_CNT - 1;
    localparam int ILV_LAST = ILV_SPAN - 1;

    always_comb begin
        hit    = 1'b0;
        port_b = 1'b0;
        idx    = IDX_DIR;
        if (sep_mode) begin
            last_addr = ADDR_W'(SEP_LAST);
            if ((int'(addr) < 2 * SEP_STRIDE) &&
                (int'(addr % ADDR_W'(SEP_STRIDE)) < REG_CNT)) begin
                hit    = 1'b1;
                port_b = addr[4];
                idx    = reg_idx_e'(addr[3:0]);
            end
        end else begin
            last_addr = ADDR_W'(ILV_LAST);
            if (int'(addr) < ILV_SPAN) begin
                hit    = 1'b1;
                port_b = addr[0];
                idx    = reg_idx_e'(addr[4:1]);
            end
        end
    end
endmodule

// File: rtl/gpx_pointer.sv
module gpx_pointer #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              hold,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_addr;
        end else if (step && !hold) begin
            ptr_d = (ptr_q == last_addr) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && hold) |=> (ptr_q == $past(ptr_q)));

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && !hold && ptr_q == last_addr) |=> (ptr_q == '0));

    p_ptr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == $past(load_addr)));
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output port_regs_t        regs
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (idx)
                IDX_DIR:  regs_d.dir  = wdata;
                IDX_POL:  regs_d.pol  = wdata;
                IDX_IEN:  regs_d.ien  = wdata;
                IDX_DFLT: regs_d.dflt = wdata;
                IDX_ICTL: regs_d.ictl = wdata;
                IDX_PULL: regs_d.pull = wdata;
                IDX_PORT,
                IDX_LAT:  regs_d.lat  = wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.dir <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

    p_port_wr_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_PORT) |=> (regs_q.lat == $past(wdata)));

    p_ro_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (idx == IDX_FLAG || idx == IDX_CAP)) |=> (regs_q == $past(regs_q)));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pull_en,
    input  logic [PIN_W-1:0]  int_flag,
    input  logic [PIN_W-1:0]  int_cap,
    output logic [DATA_W-1:0] cfg
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              sep_mode;
    logic              hold_ptr;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] last_addr;
    logic              hit;
    logic              port_b;
    reg_idx_e          idx;
    logic              wr_hit;
    port_regs_t        bank_regs [NUM_PORTS];

    assign sep_mode = st_q.cfg[CFG_MAP_BIT];
    assign hold_ptr = st_q.cfg[CFG_HLD_BIT];
    assign wr_hit   = acc_wr && !acc_ld && hit;

    gpx_map #(.ADDR_W(ADDR_W)) u_map (
        .addr      (ptr),
        .sep_mode  (sep_mode),
        .hit       (hit),
        .port_b    (port_b),
        .idx       (idx),
        .last_addr (last_addr)
    );

    gpx_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc_ld),
        .load_addr (acc_addr),
        .step      (acc_wr || acc_rd),
        .hold      (hold_ptr),
        .last_addr (last_addr),
        .ptr       (ptr)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
        gpx_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hit && (port_b == (p != 0))),
            .idx   (idx),
            .wdata (acc_wdata),
            .regs  (bank_regs[p])
        );
        assign pad_oe [p*DATA_W +: DATA_W] = ~bank_regs[p].dir;
        assign pad_out[p*DATA_W +: DATA_W] = bank_regs[p].lat;
        assign pull_en[p*DATA_W +: DATA_W] = bank_regs[p].pull;
    end

    always_comb begin
        st_d = st_q;
        if (wr_hit && idx == IDX_CFG) st_d.cfg = acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    always_comb begin
        port_regs_t        r;
        logic [DATA_W-1:0] pin_b;
        logic [DATA_W-1:0] flg_b;
        logic [DATA_W-1:0] cap_b;
        r     = port_b ? bank_regs[1] : bank_regs[0];
        pin_b = port_b ? pad_in  [DATA_W +: DATA_W] : pad_in  [0 +: DATA_W];
        flg_b = port_b ? int_flag[DATA_W +: DATA_W] : int_flag[0 +: DATA_W];
        cap_b = port_b ? int_cap [DATA_W +: DATA_W] : int_cap [0 +: DATA_W];
        acc_rdata = '0;
        if (hit) begin
            unique case (idx)
                IDX_DIR:  acc_rdata = r.dir;
                IDX_POL:  acc_rdata = r.pol;
                IDX_IEN:  acc_rdata = r.ien;
                IDX_DFLT: acc_rdata = r.dflt;
                IDX_ICTL: acc_rdata = r.ictl;
                IDX_CFG:  acc_rdata = st_q.cfg;
                IDX_PULL: acc_rdata = r.pull;
                IDX_FLAG: acc_rdata = flg_b;
                IDX_CAP:  acc_rdata = cap_b;
                IDX_PORT: acc_rdata = pin_b ^ r.pol;
                IDX_LAT:  acc_rdata = r.lat;
                default:  acc_rdata = '0;
            endcase
        end
    end

    p_cfg_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == IDX_CFG) |=> (cfg == $past(acc_wdata)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (acc_rdata == '0));
endmodule

// File: tb/sim_gpx_regfile.sv
module sim_gpx_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_ld = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [15:0] pad_in = 16'h1234;
    logic [15:0] pad_oe, pad_out, pull_en;
    logic [15:0] int_flag = 16'h3C00;
    logic [15:0] int_cap  = 16'h00E1;
    logic [7:0]  cfg;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    gpx_regfile u0 (
        .clk(clk), .rst_n(rst_n), .acc_ld(acc_ld), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pull_en(pull_en), .int_flag(int_flag),
        .int_cap(int_cap), .cfg(cfg)
    );

    localparam logic [1:0] OP_LD = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam int NV = 64;
    // {req, op, value, expected}
    localparam logic [21:0] VEC [NV] = '{
        {4'd2, OP_LD, 8'h00, 8'h00},
        {4'd2, OP_RD, 8'h00, 8'hFF},  // R2 dir A at 0x00
        {4'd2, OP_RD, 8'h00, 8'hFF},  // R2 dir B at 0x01
        {4'd2, OP_RD, 8'h00, 8'h00},  // R2 pol A at 0x02
        {4'd2, OP_LD, 8'h14, 8'h00},
        {4'd2, OP_WR, 8'h5A, 8'h00},  // latch A
        {4'd2, OP_WR, 8'hC3, 8'h00},  // latch B, pointer wraps
        {4'd6, OP_RD, 8'h00, 8'hFF},  // R6 wrap after 0x15
        {4'd2, OP_LD, 8'h00, 8'h00},
        {4'd2, OP_WR, 8'h0F, 8'h00},
        {4'd2, OP_WR, 8'hF0, 8'h00},
        {4'd4, OP_LD, 8'h0A, 8'h00},
        {4'd4, OP_WR, 8'h20, 8'h00},  // set hold bit via port A slot
        {4'd4, OP_RD, 8'h00, 8'h20},  // R4 seen via port B slot 0x0B
        {4'd5, OP_RD, 8'h00, 8'h20},  // R5 pointer held
        {4'd3, OP_LD, 8'h0B, 8'h00},
        {4'd3, OP_WR, 8'hA0, 8'h00},  // separated map + hold
        {4'd10, OP_RD, 8'h00, 8'h00}, // R10 0x0B unmapped now
        {4'd4, OP_LD, 8'h05, 8'h00},
        {4'd4, OP_RD, 8'h00, 8'hA0},  // R4 cfg at 0x05
        {4'd4, OP_LD, 8'h15, 8'h00},
        {4'd4, OP_RD, 8'h00, 8'hA0},  // R4 cfg at 0x15
        {4'd3, OP_LD, 8'h1A, 8'h00},
        {4'd3, OP_RD, 8'h00, 8'hC3},  // R3 latch B
        {4'd3, OP_LD, 8'h0A, 8'h00},
        {4'd3, OP_RD, 8'h00, 8'h5A},  // R3 latch A
        {4'd3, OP_LD, 8'h10, 8'h00},
        {4'd3, OP_RD, 8'h00, 8'hF0},  // R3 dir B
        {4'd8, OP_LD, 8'h09, 8'h00},
        {4'd8, OP_RD, 8'h00, 8'h34},  // R8 pad A, polarity 0
        {4'd8, OP_LD, 8'h01, 8'h00},
        {4'd8, OP_WR, 8'hFF, 8'h00},
        {4'd8, OP_LD, 8'h09, 8'h00},
        {4'd8, OP_RD, 8'h00, 8'hCB},  // R8 inverted
        {4'd9, OP_LD, 8'h19, 8'h00},
        {4'd9, OP_WR, 8'h77, 8'h00},
        {4'd9, OP_LD, 8'h1A, 8'h00},
        {4'd9, OP_RD, 8'h00, 8'h77},  // R9 port write -> latch B
        {4'd10, OP_LD, 8'h07, 8'h00},
        {4'd10, OP_WR, 8'h55, 8'h00},
        {4'd10, OP_RD, 8'h00, 8'h00}, // R10 flag A unchanged
        {4'd10, OP_LD, 8'h17, 8'h00},
        {4'd10, OP_RD, 8'h00, 8'h3C}, // R10 flag B
        {4'd10, OP_LD, 8'h08, 8'h00},
        {4'd10, OP_RD, 8'h00, 8'hE1}, // R10 capture A
        {4'd10, OP_LD, 8'h18, 8'h00},
        {4'd10, OP_RD, 8'h00, 8'h00}, // R10 capture B
        {4'd6, OP_LD, 8'h05, 8'h00},
        {4'd6, OP_WR, 8'h80, 8'h00},  // release hold, keep separated
        {4'd6, OP_LD, 8'h1A, 8'h00},
        {4'd6, OP_RD, 8'h00, 8'h77},
        {4'd6, OP_RD, 8'h00, 8'h0F},  // R6 wrap after 0x1A
        {4'd2, OP_LD, 8'h15, 8'h00},
        {4'd2, OP_WR, 8'h00, 8'h00},  // back to interleaved
        {4'd2, OP_LD, 8'h00, 8'h00},
        {4'd2, OP_RD, 8'h00, 8'h0F},
        {4'd2, OP_RD, 8'h00, 8'hF0},
        {4'd10, OP_LD, 8'h16, 8'h00},
        {4'd10, OP_WR, 8'h99, 8'h00}, // unmapped write
        {4'd10, OP_LD, 8'h14, 8'h00},
        {4'd10, OP_RD, 8'h00, 8'h5A},
        {4'd10, OP_RD, 8'h00, 8'h77},
        {4'd7, OP_LD, 8'h0C, 8'h00},
        {4'd7, OP_WR, 8'h81, 8'h00}   // pull A
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] val,
                         input logic [7:0] exp, input int req);
        @(negedge clk);
        acc_ld    = (op == OP_LD);
        acc_wr    = (op == OP_WR);
        acc_rd    = (op == OP_RD);
        acc_addr  = val;
        acc_wdata = val;
        #1;
        if (op == OP_RD) check(req, {8'h00, acc_rdata}, {8'h00, exp});
        @(posedge clk);
        #1;
        acc_ld = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, pad_oe, 16'h0000);
        check(1, pad_out, 16'h0000);
        check(1, {8'h00, cfg}, 16'h0000);
        check(1, {8'h00, acc_rdata}, 16'h00FF);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], int'(VEC[i][21:18]));
        end
        @(negedge clk);
        // R7 pad drive follows direction and latch
        check(7, pad_oe, 16'h0FF0);
        check(7, pad_out, 16'h775A);
        check(7, pull_en, 16'h0081);
        check(2, {8'h00, cfg}, 16'h0000);
        // R11 load wins over write in the same cycle
        @(negedge clk);
        acc_ld = 1'b1; acc_wr = 1'b1; acc_addr = 8'h14; acc_wdata = 8'h11;
        @(posedge clk);
        #1 acc_ld = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        check(11, {8'h00, acc_rdata}, 16'h005A);
        check(11, pad_out, 16'h775A);
        // R8 port read ignores direction: input pins of B
        apply(OP_LD, 8'h13, 8'h00, 8);
        apply(OP_RD, 8'h00, 8'h12, 8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule